// File: doc/BRIEF.md
# Dual-Mode Transmit Bit Stuffer

This block sits on the transmit path of a controller-area network XL frame builder and inserts stuff bits into a serial bit stream. The upstream frame builder supplies one raw bit per handshake together with a phase selector. During the first arbitration phase the block stuffs by run length. During the XL data phase it stuffs by position. During the closing arbitration phase it passes bits through unchanged. Each stuff bit always takes the inverse value of the bit emitted just before it, and a flag beside every output bit says whether that bit was inserted.

Both stream sides use valid/ready. An input bit is taken when `in_valid` and `in_ready` are both high at a rising clock edge. An output bit is consumed when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output bit and its flag hold. Because each emitted stuff bit occupies one output slot, `in_ready` drops for that slot, so back-pressure from a stuff bit reaches the source and no input bit is lost. The phase selector and the data-start marker are plain control pins. The phase should change only while no input bit is waiting.

The block also counts the run-length stuff bits of the current frame modulo 4. It latches the count when the phase leaves the first arbitration phase and presents it in Gray code with an even-parity bit, ready for the frame builder to serialise.

Top module: `xl_bit_stuffer`

## Requirements
- R1: With `phase` = 2'b00 (first arbitration), once five consecutive emitted bits share one value, the next output slot carries a stuff bit of the opposite value.
- R2: A run-length stuff bit starts the following run. For example, five zeros then four ones give a stuff one after the zeros and then a stuff zero after the fourth one.
- R3: With `phase` = 2'b01 (data), a stuff bit opposite to the preceding bit follows every tenth data bit, whatever the bit pattern. The position count restarts when an input bit is accepted with `data_start` high, and that bit counts as position one.
- R4: With `phase` = 2'b10 or 2'b11 (closing arbitration), bits pass through with no stuff bits inserted.
- R5: `out_stuff` is high exactly for output bits that the block inserted, and low for bits taken from the input.
- R6: `in_ready` is low in every slot in which a stuff bit is pending, so the input sequence appears on the output complete and in order under any `out_ready` pattern.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_stuff` hold their values.
- R8: The run-length stuff count wraps modulo 4. It clears when `phase` enters 2'b00, and it is latched onto the count outputs one cycle after `phase` leaves 2'b00. Other phases leave the latched value unchanged.
- R9: The count is output as Gray code `cnt_gray` with even parity `cnt_par`: 0 gives 00/0, 1 gives 01/1, 2 gives 11/0 and 3 gives 10/1.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, `cnt_gray` is 00 and `cnt_par` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 2 | 00 first arbitration, 01 data, 10/11 closing arbitration |
| data_start | input | 1 | Marks the accepted bit as the first data-phase bit |
| in_valid | input | 1 | Raw input bit valid |
| in_ready | output | 1 | Block can take a raw bit this cycle |
| in_bit | input | 1 | Raw input bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream takes the output bit |
| out_bit | output | 1 | Stuffed stream bit |
| out_stuff | output | 1 | High when `out_bit` is an inserted bit |
| cnt_gray | output | 2 | Latched run-length stuff count, Gray coded |
| cnt_par | output | 1 | Even parity over `cnt_gray` |

## Verification
The assertions check the cycle-level rules on every cycle. They check that a stalled output holds, that a stuff bit inverts the bit before it, that an accepted input bit is never followed by a stuff flag, that the closing phase never arms a stuff, that the count code has even parity, and that the run and position counters stay within range. Only the bench's scenarios can show where stuff bits fall in the stream. Through those scenarios it also shows that a stuff bit counts toward the next run, that `data_start` restarts the position count, that nothing is lost under irregular back-pressure, and that the latched count wraps through all four Gray codes.

// File: rtl/xl_stuff_pkg.sv
package xl_stuff_pkg;
  typedef enum logic [1:0] {
    PH_ARB1 = 2'b00,
    PH_DATA = 2'b01,
    PH_ARB2 = 2'b10
  } xl_phase_e;
endpackage

// File: rtl/xl_run_tracker.sv
// Run-length tracker for the first arbitration phase.
module xl_run_tracker #(
  parameter int RUN_LEN = 5,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             bit_in,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0]    run_q, run_base, run_nxt;
  logic             last_q;
  logic [CNT_W-1:0] cnt_q, cnt_base;

  always_comb begin
    run_base = clr ? '0 : run_q;
    cnt_base = clr ? '0 : cnt_q;
    if (run_base != '0 && bit_in == last_q) run_nxt = run_base + 1'b1;
    else                                   run_nxt = CW'(1);
    hit = step && (run_nxt == CW'(RUN_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else if (step) begin
      if (hit) begin
        // the inserted bit begins the next run
        run_q  <= CW'(1);
        last_q <= ~bit_in;
        cnt_q  <= cnt_base + 1'b1;
      end else begin
        run_q  <= run_nxt;
        last_q <= bit_in;
        cnt_q  <= cnt_base;
      end
    end else if (clr) begin
      run_q <= '0;
      cnt_q <= '0;
    end
  end

  assign cnt = cnt_q;

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(RUN_LEN)); // R1
endmodule

// File: rtl/xl_pos_tracker.sv
// Position counter for the data phase.
module xl_pos_tracker #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic hit
);
  localparam int PW = $clog2(PERIOD + 1);

  logic [PW-1:0] pos_q, pos_inc;

  always_comb begin
    pos_inc = (restart ? '0 : pos_q) + 1'b1;
    hit     = step && (pos_inc == PW'(PERIOD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= '0;
    else if (step) pos_q <= hit ? '0 : pos_inc;
  end

  AST_POS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < PW'(PERIOD)); // R3
endmodule

// File: rtl/xl_gray_par.sv
// Binary to Gray code with even parity.
module xl_gray_par #(
  parameter int W = 2
) (
  input  logic [W-1:0] bin,
  output logic [W-1:0] gray,
  output logic         par
);
  assign gray = bin ^ (bin >> 1);
  assign par  = ^gray;
endmodule

// File: rtl/xl_bit_stuffer.sv
module xl_bit_stuffer
  import xl_stuff_pkg::*;
#(
  parameter int DYN_RUN    = 5,
  parameter int FIX_PERIOD = 10,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase,
  input  logic             data_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bit,
  output logic             out_stuff,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             cnt_par
);
  logic [1:0]       phase_q;
  logic             in_dyn, in_fix, dyn_clr, dyn_leave;
  logic             load_en, accept, dyn_hit, fix_hit;
  logic             stuff_pend, prev_q;
  logic [CNT_W-1:0] dyn_cnt, cnt_latch;

  assign in_dyn    = (phase == PH_ARB1);
  assign in_fix    = (phase == PH_DATA);
  assign dyn_clr   = in_dyn && (phase_q != PH_ARB1);
  assign dyn_leave = (phase_q == PH_ARB1) && !in_dyn;

  assign load_en  = !out_valid || out_ready;
  assign in_ready = load_en && !stuff_pend;
  assign accept   = in_valid && in_ready;

  xl_run_tracker #(.RUN_LEN(DYN_RUN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(dyn_clr), .step(accept && in_dyn),
    .bit_in(in_bit), .hit(dyn_hit), .cnt(dyn_cnt)
  );

  xl_pos_tracker #(.PERIOD(FIX_PERIOD)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(accept && in_fix),
    .restart(data_start), .hit(fix_hit)
  );

  xl_gray_par #(.W(CNT_W)) u_code (
    .bin(cnt_latch), .gray(cnt_gray), .par(cnt_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_ARB2;
      cnt_latch <= '0;
    end else begin
      phase_q <= phase;
      if (dyn_leave) cnt_latch <= dyn_cnt;
    end
  end

  // single output slot; a pending stuff takes the next slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bit    <= 1'b0;
      out_stuff  <= 1'b0;
      stuff_pend <= 1'b0;
      prev_q     <= 1'b0;
    end else if (load_en) begin
      if (stuff_pend) begin
        prev_q     <= out_bit;
        out_bit    <= ~out_bit;
        out_stuff  <= 1'b1;
        out_valid  <= 1'b1;
        stuff_pend <= 1'b0;
      end else if (accept) begin
        prev_q     <= out_bit;
        out_bit    <= in_bit;
        out_stuff  <= 1'b0;
        out_valid  <= 1'b1;
        stuff_pend <= dyn_hit || fix_hit;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_stuff)); // R7
  AST_STUFF_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stuff |-> out_bit != prev_q); // R1
  AST_NO_STUFF_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !out_stuff); // R6
  AST_PASS_NO_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_dyn && !in_fix |=> !stuff_pend); // R4
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({cnt_gray, cnt_par}) % 2) == 0); // R9
endmodule

// File: tb/xl_bit_stuffer_tb.sv
module xl_bit_stuffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase = 2'b10;
  logic       data_start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_bit, out_stuff, cnt_par;
  logic [1:0] cnt_gray;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic exp_b [0:127];
  logic exp_s [0:127];
  logic got_b [0:127];
  logic got_s [0:127];
  int   exp_n;

  always #5 clk = ~clk;

  xl_bit_stuffer u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .data_start(data_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_stuff(out_stuff), .cnt_gray(cnt_gray), .cnt_par(cnt_par)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic b, input logic s);
    if (exp_n < 128) begin
      exp_b[exp_n] = b;
      exp_s[exp_n] = s;
    end
    exp_n++;
  endtask

  // expected stream straight from R1..R4
  task automatic build_exp(input logic [1:0] ph, input logic [63:0] pat, input int n,
                           input int restart_at);
    logic last = 1'b0;
    int   run = 0;
    int   pos = 0;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      logic b = pat[i];
      push_exp(b, 1'b0);
      if (ph == 2'b00) begin
        run  = (run != 0 && b == last) ? run + 1 : 1;
        last = b;
        if (run == 5) begin
          push_exp(~b, 1'b1);
          last = ~b;
          run  = 1;
        end
      end else if (ph == 2'b01) begin
        if (i == 0 || i == restart_at) pos = 0;
        pos++;
        if (pos == 10) begin
          push_exp(~b, 1'b1);
          pos = 0;
        end
      end
    end
  endtask

  task automatic run_stream(input logic [1:0] ph, input logic [63:0] pat, input int n,
                            input int restart_at, input bit bp, input string req);
    int idx = 0;
    int got = 0;
    int cyc = 0;
    int hold_bad = 0;
    int first_bad = -1;
    bit stall_prev = 1'b0;
    logic pb = 1'b0;
    logic ps = 1'b0;
    build_exp(ph, pat, n, restart_at);
    @(negedge clk);
    phase = ph;
    repeat (2) @(negedge clk);
    while ((idx < n || got < exp_n) && cyc < 1000) begin
      in_valid   = (idx < n);
      in_bit     = (idx < n) ? pat[idx] : 1'b0;
      data_start = (ph == 2'b01) && (idx == 0 || idx == restart_at);
      out_ready  = bp ? ((cyc % 3) != 1) : 1'b1;
      if (stall_prev && (!out_valid || out_bit != pb || out_stuff != ps)) hold_bad++;
      #1;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        if (got < 128) begin
          got_b[got] = out_bit;
          got_s[got] = out_stuff;
        end
        got++;
      end
      stall_prev = out_valid && !out_ready;
      pb = out_bit;
      ps = out_stuff;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    data_start = 1'b0;
    out_ready = 1'b1;
    check(got == exp_n, {req, " length"}, got, exp_n);
    for (int k = 0; k < exp_n && k < got && k < 128; k++)
      if (first_bad < 0 && (got_b[k] != exp_b[k] || got_s[k] != exp_s[k])) first_bad = k;
    check(first_bad < 0, {req, " bit/flag mismatch at index (act) vs none (exp)"}, first_bad, -1);
    if (bp) check(hold_bad == 0, "R7 stalled output changed", hold_bad, 0);
    phase = 2'b10;
    repeat (2) @(negedge clk);
  endtask

  // R9 code table
  task automatic check_cnt(input int cnt, input string req);
    logic [2:0] e;
    case (cnt % 4)
      0: e = 3'b000;
      1: e = 3'b011;
      2: e = 3'b110;
      default: e = 3'b101;
    endcase
    check({cnt_gray, cnt_par} == e, req, int'({cnt_gray, cnt_par}), int'(e));
  endtask

  task automatic t_reset;
    #1;
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    check({cnt_gray, cnt_par} == 3'b000, "R10 count code", int'({cnt_gray, cnt_par}), 0);
  endtask

  task automatic t_dyn_zeros;      // R1 R5 R8 R9: two stuffs
    run_stream(2'b00, 64'h0, 11, -1, 1'b0, "R1 R5 eleven zeros");
    check_cnt(2, "R8 R9 count after two stuffs");
  endtask

  task automatic t_dyn_chain;      // R2: 00000 1111 0
    run_stream(2'b00, 64'b0_1111_00000, 10, -1, 1'b0, "R2 stuff starts next run");
    check_cnt(2, "R2 R8 count after chained stuffs");
  endtask

  task automatic t_dyn_alt;        // R1: no long run, count clears on entry
    run_stream(2'b00, 64'h5555, 16, -1, 1'b0, "R1 alternating no stuff");
    check_cnt(0, "R8 R9 count cleared on entry");
  endtask

  task automatic t_dyn_bp;         // R6 R7: fifteen ones under back-pressure
    run_stream(2'b00, 64'h7FFF, 15, -1, 1'b1, "R6 back-pressure dynamic");
    check_cnt(3, "R9 count three");
  endtask

  task automatic t_dyn_wrap;       // R8: five stuffs wrap to one
    run_stream(2'b00, 64'h0, 25, -1, 1'b0, "R1 twenty-five zeros");
    check_cnt(1, "R8 R9 count wraps modulo 4");
  endtask

  task automatic t_fixed;          // R3: pattern-independent position stuffing
    run_stream(2'b01, 64'h0155_5555, 25, -1, 1'b0, "R3 fixed every tenth");
    run_stream(2'b01, 64'h0, 22, 6, 1'b1, "R3 R6 fixed restart on marker");
    check_cnt(1, "R8 data phase keeps latched count");
  endtask

  task automatic t_pass;           // R4
    run_stream(2'b10, 64'h0, 12, -1, 1'b0, "R4 closing phase no stuff");
    run_stream(2'b11, 64'hFFF, 12, -1, 1'b1, "R4 phase 11 no stuff");
    check_cnt(1, "R4 R8 latched count unchanged");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_dyn_zeros();
    t_dyn_chain();
    t_dyn_alt();
    t_dyn_bp();
    t_dyn_wrap();
    t_fixed();
    t_pass();
    finish_run();
  end
endmodule